// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address by reading descriptors from a two-level translation table in memory. A request enters over a valid/ready handshake together with a table base. The walker then reads one or two descriptor words over a simple strobe/response memory port. It reports the physical address, a fault flag and the memory attribute bits of the final descriptor.

The first level can map a whole 1 MB section directly, or it can point at a 256-entry second-level table. That table maps 64 KB large pages or 4 KB small pages. Any other descriptor type ends the walk with a fault. Only one walk is in progress at a time, so `req_ready` is the back-pressure: a requester holding `req_valid` waits until the walker is idle.

The result is a one-cycle `res_valid` pulse that cannot be stalled. The memory port has no ready signal either. The walker issues a one-cycle `mem_req` strobe and accepts the first `mem_rsp_valid` that follows, however late it comes.

Top module: `ptw_walker`

## Requirements
- R1: `req_ready` is high exactly when no walk is in progress, and it is high after reset. A request is taken at a rising edge where `req_valid` and `req_ready` are both high, and `req_vaddr` and `tbl_base` are captured at that edge. `req_valid` has no effect while a walk is in progress.
- R2: In the cycle after acceptance, `mem_req` is high for exactly one cycle with `mem_addr` = {`tbl_base`[31:14], va[31:20], 2'b00}.
- R3: After a read strobe, the walker waits any number of cycles for `mem_rsp_valid`, and it issues no new strobe while it waits. A `mem_rsp_valid` that arrives while no read is outstanding is ignored.
- R4: A first-level descriptor d with d[1:0]=2'b10 is a section. The result is `res_paddr` = {d[31:20], va[19:0]}, `res_bufd`=d[2], `res_cached`=d[3], `res_ext`=d[12] and no fault. It appears in the cycle after the response.
- R5: A first-level descriptor d with d[1:0]=2'b01 points to a coarse table. In the cycle after the response, a second read is strobed at {d[31:10], va[19:12], 2'b00}.
- R6: A second-level descriptor e with e[1:0]=2'b01 is a large page. The result is `res_paddr` = {e[31:16], va[15:0]}, `res_bufd`=e[2], `res_cached`=e[3], `res_ext`=0 and no fault.
- R7: A second-level descriptor e with e[1:0]=2'b10 is a small page. The result is `res_paddr` = {e[31:12], va[11:0]}, `res_bufd`=e[2], `res_cached`=e[3], `res_ext`=0 and no fault.
- R8: A first-level type of 2'b00 or 2'b11, or a second-level type of 2'b00 or 2'b11, ends the walk. The result has `res_fault`=1, and `res_paddr`, `res_bufd`, `res_cached` and `res_ext` are all 0. A first-level fault issues no second read.
- R9: `res_valid` is a single-cycle pulse, and `req_ready` is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| tbl_base | input | 32 | First-level table base; bits 13:0 are ignored |
| mem_req | output | 1 | One-cycle descriptor read strobe |
| mem_addr | output | 32 | Descriptor word address, valid with `mem_req` |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Descriptor word |
| res_valid | output | 1 | Result pulse |
| res_fault | output | 1 | Walk ended on an unhandled descriptor type |
| res_paddr | output | 32 | Translated physical address |
| res_bufd | output | 1 | Buffered attribute of the final descriptor |
| res_cached | output | 1 | Cached attribute of the final descriptor |
| res_ext | output | 1 | Extension bit (sections only) |

## Verification
The hardest behaviour to reach from the ports is a stray response or a repeated request that arrives while the walker is busy in a state that must not react to it. Examples are a response in the strobe cycle itself, or one while idle, with `req_valid` held high and a different address throughout the walk. The bench drives these on purpose alongside variable response latencies. A cycle-level behavioural model then confirms that strobes, addresses and results are unchanged. Random descriptor types cover every decode path at both levels.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W        = 32;
  localparam int L1_IDX_W    = 12;
  localparam int L2_IDX_W    = 8;
  localparam int WORD_LSB    = 2;
  localparam int SEC_OFF_W   = VA_W - L1_IDX_W;
  localparam int PAGE_OFF_W  = SEC_OFF_W - L2_IDX_W;
  localparam int LARGE_OFF_W = 16;
  localparam int L1_BASE_LSB = L1_IDX_W + WORD_LSB;
  localparam int L2_BASE_LSB = L2_IDX_W + WORD_LSB;

  localparam logic [1:0] L1_T_SECTION = 2'b10;
  localparam logic [1:0] L1_T_COARSE  = 2'b01;
  localparam logic [1:0] L2_T_LARGE   = 2'b01;
  localparam logic [1:0] L2_T_SMALL   = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE
  } walk_state_e;

  typedef struct packed {
    logic            fault;
    logic [VA_W-1:0] paddr;
    logic            bufd;
    logic            cached;
    logic            ext;
  } xlat_res_t;
endpackage

// File: rtl/ptw_l1_dec.sv
module ptw_l1_dec
  import ptw_pkg::*;
(
  input  logic [VA_W-1:0]        desc,
  input  logic [SEC_OFF_W-1:0]   va_off,
  output logic                   is_table,
  output logic [VA_W-1:L2_BASE_LSB] l2_base,
  output xlat_res_t              res
);
  logic unused_l1;
  assign unused_l1 = ^desc[L2_BASE_LSB-1:4];

  assign is_table = (desc[1:0] == L1_T_COARSE);
  assign l2_base  = desc[VA_W-1:L2_BASE_LSB];

  always_comb begin
    res = '0;
    if (desc[1:0] == L1_T_SECTION) begin
      res.paddr  = {desc[VA_W-1:SEC_OFF_W], va_off};
      res.bufd   = desc[2];
      res.cached = desc[3];
      res.ext    = desc[12];
    end else if (!is_table) begin
      res.fault  = 1'b1;
    end
  end
endmodule

// File: rtl/ptw_l2_dec.sv
module ptw_l2_dec
  import ptw_pkg::*;
(
  input  logic [VA_W-1:0]        desc,
  input  logic [LARGE_OFF_W-1:0] va_off,
  output xlat_res_t              res
);
  logic unused_l2;
  assign unused_l2 = ^desc[PAGE_OFF_W-1:4];

  always_comb begin
    res = '0;
    case (desc[1:0])
      L2_T_LARGE: begin
        res.paddr  = {desc[VA_W-1:LARGE_OFF_W], va_off};
        res.bufd   = desc[2];
        res.cached = desc[3];
      end
      L2_T_SMALL: begin
        res.paddr  = {desc[VA_W-1:PAGE_OFF_W], va_off[PAGE_OFF_W-1:0]};
        res.bufd   = desc[2];
        res.cached = desc[3];
      end
      default: res.fault = 1'b1;
    endcase
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [31:0]     req_vaddr,
  input  logic [31:0]     tbl_base,
  output logic            mem_req,
  output logic [31:0]     mem_addr,
  input  logic            mem_rsp_valid,
  input  logic [31:0]     mem_rsp_data,
  output logic            res_valid,
  output logic            res_fault,
  output logic [31:0]     res_paddr,
  output logic            res_bufd,
  output logic            res_cached,
  output logic            res_ext
);
  walk_state_e                   state;
  logic [VA_W-1:0]               va_q;
  logic [VA_W-1:L1_BASE_LSB]     base_q;
  logic [VA_W-1:L2_BASE_LSB]     l2b_q;
  xlat_res_t                     res_q;

  logic                          l1_is_table;
  logic [VA_W-1:L2_BASE_LSB]     l1_l2_base;
  xlat_res_t                     l1_res;
  xlat_res_t                     l2_res;

  logic unused_top;
  assign unused_top = ^tbl_base[L1_BASE_LSB-1:0];

  ptw_l1_dec u_l1 (
    .desc     (mem_rsp_data),
    .va_off   (va_q[SEC_OFF_W-1:0]),
    .is_table (l1_is_table),
    .l2_base  (l1_l2_base),
    .res      (l1_res)
  );

  ptw_l2_dec u_l2 (
    .desc   (mem_rsp_data),
    .va_off (va_q[LARGE_OFF_W-1:0]),
    .res    (l2_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      va_q   <= '0;
      base_q <= '0;
      l2b_q  <= '0;
      res_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          base_q <= tbl_base[VA_W-1:L1_BASE_LSB];
          state  <= ST_L1_REQ;
        end
        ST_L1_REQ: state <= ST_L1_WAIT;
        ST_L1_WAIT: if (mem_rsp_valid) begin
          if (l1_is_table) begin
            l2b_q <= l1_l2_base;
            state <= ST_L2_REQ;
          end else begin
            res_q <= l1_res;
            state <= ST_DONE;
          end
        end
        ST_L2_REQ: state <= ST_L2_WAIT;
        ST_L2_WAIT: if (mem_rsp_valid) begin
          res_q <= l2_res;
          state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic second_lvl;
  assign second_lvl = (state == ST_L2_REQ) || (state == ST_L2_WAIT);

  always_comb begin
    if (second_lvl)
      mem_addr = {l2b_q, va_q[SEC_OFF_W-1:PAGE_OFF_W], 2'b00};
    else
      mem_addr = {base_q, va_q[VA_W-1:SEC_OFF_W], 2'b00};
  end

  assign req_ready  = (state == ST_IDLE);
  assign mem_req    = (state == ST_L1_REQ) || (state == ST_L2_REQ);
  assign res_valid  = (state == ST_DONE);
  assign res_fault  = res_q.fault;
  assign res_paddr  = res_q.paddr;
  assign res_bufd   = res_q.bufd;
  assign res_cached = res_q.cached;
  assign res_ext    = res_q.ext;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_vaddr,
  input logic [31:0] tbl_base,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        mem_rsp_valid,
  input logic [31:0] mem_rsp_data,
  input logic        res_valid,
  input logic        res_fault,
  input logic [31:0] res_paddr,
  input logic        res_bufd,
  input logic        res_cached,
  input logic        res_ext
);
  logic [19:0] va_c;
  logic [1:0]  n_req;
  logic        outst;
  logic        l1_rsp, l2_rsp;
  logic unused_chk;
  assign unused_chk = ^{tbl_base[13:0], mem_rsp_data[9:4]};

  always_ff @(posedge clk) begin
    if (rst) begin
      va_c <= '0; n_req <= '0; outst <= 1'b0;
    end else begin
      if (req_valid && req_ready) begin
        va_c <= req_vaddr[19:0];
        n_req <= '0;
      end else if (mem_req) begin
        n_req <= n_req + 2'd1;
      end
      if (mem_req) outst <= 1'b1;
      else if (mem_rsp_valid) outst <= 1'b0;
    end
  end

  assign l1_rsp = outst && mem_rsp_valid && (n_req == 2'd1);
  assign l2_rsp = outst && mem_rsp_valid && (n_req == 2'd2);

  // R1
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!mem_req && !res_valid));
  // R2
  p_l1_addr_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (mem_req &&
      mem_addr == {$past(tbl_base[31:14]), $past(req_vaddr[31:20]), 2'b00}));
  // R2
  p_strobe_single_r2: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);
  // R4
  p_section_r4: assert property (@(posedge clk) disable iff (rst)
    (l1_rsp && mem_rsp_data[1:0] == 2'b10) |=> (res_valid && !res_fault &&
      res_paddr == {$past(mem_rsp_data[31:20]), va_c}));
  // R5
  p_l2_issue_r5: assert property (@(posedge clk) disable iff (rst)
    (l1_rsp && mem_rsp_data[1:0] == 2'b01) |=> (mem_req &&
      mem_addr == {$past(mem_rsp_data[31:10]), va_c[19:12], 2'b00}));
  // R7
  p_small_r7: assert property (@(posedge clk) disable iff (rst)
    (l2_rsp && mem_rsp_data[1:0] == 2'b10) |=> (res_valid &&
      res_paddr == {$past(mem_rsp_data[31:12]), va_c[11:0]}));
  // R8
  p_fault_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_fault) |->
      (res_paddr == 32'd0 && !res_bufd && !res_cached && !res_ext));
  // R9
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> (!res_valid && req_ready));
endmodule

bind ptw_walker ptw_walker_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_vaddr(req_vaddr), .tbl_base(tbl_base), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
  .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_fault(res_fault),
  .res_paddr(res_paddr), .res_bufd(res_bufd), .res_cached(res_cached),
  .res_ext(res_ext)
);

// File: tb/ptw_walker_test.sv
`timescale 1ns/1ps
module ptw_walker_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [31:0] tbl_base = '0;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic req_ready, mem_req, res_valid, res_fault, res_bufd, res_cached, res_ext;
  logic [31:0] mem_addr, res_paddr;

  int n_tests = 0;
  int n_fail = 0;
  int cyc = 0;
  bit started = 0;

  always #2 clk = ~clk;

  ptw_walker uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .tbl_base(tbl_base), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_fault(res_fault),
    .res_paddr(res_paddr), .res_bufd(res_bufd), .res_cached(res_cached),
    .res_ext(res_ext)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // behavioural reference model: phase 0 idle, 1 first read, 2 first wait,
  // 3 second read, 4 second wait, 5 result
  int m_ph = 0;
  logic [31:0] m_va, m_base, m_pa;
  logic [21:0] m_l2b;
  logic m_f, m_b, m_c, m_e;
  string m_tag = "R4";

  always @(posedge clk) begin
    cyc++;
    if (rst) m_ph = 0;
    else begin
      case (m_ph)
        0: if (req_valid) begin m_va = req_vaddr; m_base = tbl_base; m_ph = 1; end
        1: m_ph = 2;
        2: if (mem_rsp_valid) begin
             logic [31:0] d; d = mem_rsp_data;
             m_f = 0; m_pa = 0; m_b = 0; m_c = 0; m_e = 0;
             if (d[1:0] == 2'b10) begin
               m_pa = {d[31:20], m_va[19:0]}; m_b = d[2]; m_c = d[3]; m_e = d[12];
               m_tag = "R4"; m_ph = 5;
             end else if (d[1:0] == 2'b01) begin
               m_l2b = d[31:10]; m_ph = 3;
             end else begin
               m_f = 1; m_tag = "R8"; m_ph = 5;
             end
           end
        3: m_ph = 4;
        4: if (mem_rsp_valid) begin
             logic [31:0] d; d = mem_rsp_data;
             m_f = 0; m_pa = 0; m_b = 0; m_c = 0; m_e = 0;
             if (d[1:0] == 2'b01) begin
               m_pa = {d[31:16], m_va[15:0]}; m_b = d[2]; m_c = d[3]; m_tag = "R6";
             end else if (d[1:0] == 2'b10) begin
               m_pa = {d[31:12], m_va[11:0]}; m_b = d[2]; m_c = d[3]; m_tag = "R7";
             end else begin
               m_f = 1; m_tag = "R8";
             end
             m_ph = 5;
           end
        default: m_ph = 0;
      endcase
    end
    #1;
    if (started) begin
      bit exp_req;
      string rt;
      exp_req = (m_ph == 1) || (m_ph == 3);
      rt = (m_ph == 2 || m_ph == 4) ? "R3" : (m_ph == 3 ? "R5" : "R2");
      chk(req_ready == (m_ph == 0), "R1", "req_ready", 32'(req_ready), 32'(m_ph == 0));
      chk(mem_req == exp_req, rt, "mem_req", 32'(mem_req), 32'(exp_req));
      if (m_ph == 1)
        chk(mem_addr == {m_base[31:14], m_va[31:20], 2'b00}, "R2", "mem_addr",
            mem_addr, {m_base[31:14], m_va[31:20], 2'b00});
      if (m_ph == 3)
        chk(mem_addr == {m_l2b, m_va[19:12], 2'b00}, "R5", "mem_addr",
            mem_addr, {m_l2b, m_va[19:12], 2'b00});
      chk(res_valid == (m_ph == 5), "R9", "res_valid", 32'(res_valid), 32'(m_ph == 5));
      if (m_ph == 5 && res_valid) begin
        chk(res_paddr == m_pa, m_tag, "res_paddr", res_paddr, m_pa);
        chk(res_fault == m_f, m_tag, "res_fault", 32'(res_fault), 32'(m_f));
        chk(res_bufd == m_b, m_tag, "res_bufd", 32'(res_bufd), 32'(m_b));
        chk(res_cached == m_c, m_tag, "res_cached", 32'(res_cached), 32'(m_c));
        chk(res_ext == m_e, m_tag, "res_ext", 32'(res_ext), 32'(m_e));
      end
    end
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic respond(input logic [31:0] d, input int lat);
    repeat (lat) begin @(negedge clk); mem_rsp_valid = 0; end
    mem_rsp_valid = 1; mem_rsp_data = d;
    @(negedge clk);
    mem_rsp_valid = 0; mem_rsp_data = 32'hDEAD_BEEF;
    req_valid = 0;
  endtask

  task automatic walk(input logic [31:0] va, input logic [31:0] base,
                      input logic [31:0] d1, input logic [31:0] d2,
                      input int lat1, input int lat2, input bit noise);
    if (noise) begin
      @(negedge clk); mem_rsp_valid = 1; mem_rsp_data = 32'h0000_0002;
    end
    @(negedge clk);
    mem_rsp_valid = 0;
    req_valid = 1; req_vaddr = va; tbl_base = base;
    @(negedge clk);
    if (noise) begin
      req_vaddr = ~va; tbl_base = ~base;
      mem_rsp_valid = 1; mem_rsp_data = 32'hFFFF_F002;
    end else req_valid = 0;
    respond(d1, lat1);
    if (d1[1:0] == 2'b01) begin
      if (noise) begin mem_rsp_valid = 1; mem_rsp_data = 32'h1111_1112; end
      respond(d2, lat2);
    end
    for (int k = 0; k < 10 && !res_valid; k++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    started = 1;
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state checked by the per-cycle comparison
    // R4 sections with differing attributes and latencies
    walk(32'hABC1_2345, 32'h1234_5FFF, 32'h5550_100E, 0, 1, 1, 0);
    walk(32'h0012_3456, 32'h8000_0000, 32'hFFF0_EFF2, 0, 6, 1, 0);
    // R5 R7 small page
    walk(32'h7654_3210, 32'h0004_0000, 32'h0040_0C01, 32'h8765_400A, 2, 3, 0);
    // R6 large page
    walk(32'h1357_9BDF, 32'hC000_0000, 32'hAAAA_AFF1, 32'h4321_FFF5, 1, 7, 0);
    // R8 fault types at both levels
    walk(32'h2222_2222, 32'h0000_4000, 32'hFFFF_FFFC, 0, 1, 1, 0);
    walk(32'h3333_3333, 32'h0000_4000, 32'hFFFF_FFFF, 0, 2, 1, 0);
    walk(32'h4444_4444, 32'h0000_8000, 32'h1234_5401, 32'hFFFF_FFFC, 1, 1, 0);
    walk(32'h5555_5555, 32'h0000_8000, 32'h1234_5401, 32'hFFFF_FFFF, 1, 2, 0);
    // R1 R3 stray responses and held request during walks
    walk(32'h9ABC_DEF0, 32'h0101_0000, 32'h0F00_0401, 32'hCAFE_B00A, 3, 4, 1);
    walk(32'h0F0F_0F0F, 32'h0202_0000, 32'h7770_000A, 0, 2, 1, 1);
    // random mix covering all decode paths
    for (int i = 0; i < 40; i++) begin
      logic [31:0] a, b, x, y;
      a = $urandom; b = $urandom; x = $urandom; y = $urandom;
      if (i % 2 == 0) x[1:0] = 2'b01;
      walk(a, b, x, y, $urandom_range(1, 5), $urandom_range(1, 5), i % 3 == 0);
    end
    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule